// File: doc/BRIEF.md
# Layout Fast Clock Follower

This block keeps a scaled layout time for a display device. A real-time reference tick drives a local sub-minute phase accumulator, to which every tick adds a programmable rate. The rate runs from 0 (clock stopped) through 1 (real time) up to 127 (127 times faster). Each time the accumulator crosses a fixed per-minute threshold, one fast minute passes. Minutes roll into hours and hours roll into a day count.

A sync record carries a control byte, a rate, minutes and hours in 256-minus-value form, a day count and a two-part setter ID. The block accepts the record only if bit 6 of the control byte is set. An accepted record reloads the time, the rate and the setter ID, and it restarts the sub-minute phase from zero.

On a read request, the block returns the current state one cycle later as an encoded record, in the same form as a sync record. Message transport is handled elsewhere.

Top module: `fclk_follower`

## Requirements
- R1: After reset, minute, hour and days are 0, the rate is 0, never_set is 1 and rec_valid is 0. The stored control byte is 0x40.
- R2: Each cycle with ref_tick high and no accepted sync adds the current rate to the phase accumulator. When the sum reaches MIN_THRESH (default 240), minute advances at that clock edge and the accumulator keeps sum minus MIN_THRESH. Otherwise the accumulator keeps the sum. With rate 0, or with no tick, the time does not change.
- R3: Minute runs 0..59. A step from 59 gives minute 0 and increments the hour at the same edge. A step from 23:59 gives 0:00 and increments days at the same edge. Days wraps modulo 128.
- R4: A sync (sync_valid high with sync_ctrl bit 6 set) loads the following at the next edge:
  - minute = ((256 − sync_min_enc) mod 256) mod 60
  - hour = ((256 − sync_hr_enc) mod 256) mod 24
  - days, the rate, both setter IDs and the control byte, taken from the record
  
  The sync also clears the phase accumulator. A tick in the same cycle is discarded.
- R5: When sync_valid is high with sync_ctrl bit 6 clear, the record has no effect on the time, the rate, the IDs or the stored control byte.
- R6: never_set is 1 exactly when both stored setter IDs are 0.
- R7: rec_valid is high for one cycle, in the cycle after each cycle with rd_req high. The record fields hold the state as it stood before that edge:
  - rec_min_enc = (256 − minute) mod 256, so 0 encodes as 0
  - rec_hr_enc = (256 − hour) mod 256
  - rec_days, rec_rate, rec_id1 and rec_id2 as stored
  - rec_ctrl = the stored control byte

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Real-time reference tick, one cycle wide |
| sync_valid | input | 1 | Sync record strobe |
| sync_ctrl | input | 8 | Control byte; bit 6 marks valid clock data |
| sync_rate | input | RATE_W | Clock rate, 0 stops the clock |
| sync_min_enc | input | 8 | 256 minus minute |
| sync_hr_enc | input | 8 | 256 minus hour |
| sync_days | input | DAY_W | Day count |
| sync_id1 | input | ID_W | Setter ID, low part |
| sync_id2 | input | ID_W | Setter ID, high part |
| rd_req | input | 1 | Request for an encoded record |
| minute | output | 6 | Current fast minute |
| hour | output | 5 | Current fast hour |
| days | output | DAY_W | Current day count |
| rate | output | RATE_W | Current rate |
| never_set | output | 1 | Both setter IDs are zero |
| rec_valid | output | 1 | Record fields are valid this cycle |
| rec_ctrl | output | 8 | Record control byte |
| rec_rate | output | RATE_W | Record rate |
| rec_min_enc | output | 8 | Record minute, 256-minus form |
| rec_hr_enc | output | 8 | Record hour, 256-minus form |
| rec_days | output | DAY_W | Record day count |
| rec_id1 | output | ID_W | Record setter ID, low part |
| rec_id2 | output | ID_W | Record setter ID, high part |

## Verification
A read request can land in the same cycle as a change of state. The bench provokes this twice:
- It raises rd_req together with the tick that rolls 23:59 into the next day.
- It raises rd_req together with an accepted sync.

In both cases the queued record must show the state from before that edge, while the outputs must already show the rolled-over or reloaded time. A tick that arrives together with an accepted sync is also checked: the partial phase must be discarded and the tick must not count.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
  localparam int MIN_BITS    = 6;
  localparam int HR_BITS     = 5;
  localparam int CODE_W      = 8;
  localparam int CTRL_W      = 8;
  localparam int VALID_BIT   = 6;
  localparam int MINS_PER_HR = 60;
  localparam int HRS_PER_DAY = 24;
  localparam logic [CTRL_W-1:0] CTRL_AT_RESET = 8'h40;

  // 256-minus-value form, taken modulo 256
  function automatic logic [CODE_W-1:0] to_code(input logic [CODE_W-1:0] v);
    return CODE_W'(8'd0 - v);
  endfunction

  function automatic logic [MIN_BITS-1:0] code_to_min(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] v;
    v = CODE_W'(8'd0 - c);
    return MIN_BITS'(v % CODE_W'(MINS_PER_HR));
  endfunction

  function automatic logic [HR_BITS-1:0] code_to_hr(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] v;
    v = CODE_W'(8'd0 - c);
    return HR_BITS'(v % CODE_W'(HRS_PER_DAY));
  endfunction
endpackage

// File: rtl/fclk_phase.sv
module fclk_phase #(
  parameter int RATE_W     = 7,
  parameter int MIN_THRESH = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clear,
  input  logic [RATE_W-1:0] rate,
  output logic              step
);
  localparam int ACC_W = $clog2(MIN_THRESH + (1 << RATE_W));

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             acc_en;

  always_comb begin
    sum    = acc_q + ACC_W'(rate);
    acc_d  = acc_q;
    step   = 1'b0;
    acc_en = clear | tick;
    if (clear) begin
      acc_d = '0;
    end else if (tick) begin
      if (sum >= ACC_W'(MIN_THRESH)) begin
        step  = 1'b1;
        acc_d = sum - ACC_W'(MIN_THRESH);
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/fclk_tod.sv
module fclk_tod
  import fclk_pkg::*;
#(
  parameter int DAY_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                load,
  input  logic [MIN_BITS-1:0] ld_min,
  input  logic [HR_BITS-1:0]  ld_hr,
  input  logic [DAY_W-1:0]    ld_days,
  output logic [MIN_BITS-1:0] minute,
  output logic [HR_BITS-1:0]  hour,
  output logic [DAY_W-1:0]    days
);
  logic [MIN_BITS-1:0] min_q, min_d;
  logic [HR_BITS-1:0]  hr_q, hr_d;
  logic [DAY_W-1:0]    day_q, day_d;
  logic                min_wrap, hr_wrap, tod_en;

  assign min_wrap = step && (min_q == MIN_BITS'(MINS_PER_HR - 1));
  assign hr_wrap  = min_wrap && (hr_q == HR_BITS'(HRS_PER_DAY - 1));
  assign tod_en   = load | step;

  always_comb begin
    min_d = min_q;
    hr_d  = hr_q;
    day_d = day_q;
    if (load) begin
      min_d = ld_min;
      hr_d  = ld_hr;
      day_d = ld_days;
    end else if (step) begin
      min_d = min_wrap ? '0 : min_q + 1'b1;
      if (min_wrap) hr_d  = hr_wrap ? '0 : hr_q + 1'b1;
      if (hr_wrap)  day_d = day_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (tod_en) begin
      min_q <= min_d;
      hr_q  <= hr_d;
      day_q <= day_d;
    end
  end

  assign minute = min_q;
  assign hour   = hr_q;
  assign days   = day_q;
endmodule

// File: rtl/fclk_snap.sv
module fclk_snap
  import fclk_pkg::*;
#(
  parameter int RATE_W = 7,
  parameter int DAY_W  = 7,
  parameter int ID_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic [MIN_BITS-1:0] minute,
  input  logic [HR_BITS-1:0]  hour,
  input  logic [DAY_W-1:0]    days,
  input  logic [RATE_W-1:0]   rate,
  input  logic [ID_W-1:0]     id1,
  input  logic [ID_W-1:0]     id2,
  input  logic [CTRL_W-1:0]   ctrl,
  output logic                rec_valid,
  output logic [CTRL_W-1:0]   rec_ctrl,
  output logic [RATE_W-1:0]   rec_rate,
  output logic [CODE_W-1:0]   rec_min_enc,
  output logic [CODE_W-1:0]   rec_hr_enc,
  output logic [DAY_W-1:0]    rec_days,
  output logic [ID_W-1:0]     rec_id1,
  output logic [ID_W-1:0]     rec_id2
);
  logic [CODE_W-1:0] min_code, hr_code;

  assign min_code = to_code(CODE_W'(minute));
  assign hr_code  = to_code(CODE_W'(hour));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_valid <= 1'b0;
    else        rec_valid <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_ctrl    <= '0;
      rec_rate    <= '0;
      rec_min_enc <= '0;
      rec_hr_enc  <= '0;
      rec_days    <= '0;
      rec_id1     <= '0;
      rec_id2     <= '0;
    end else if (rd_req) begin
      rec_ctrl    <= ctrl;
      rec_rate    <= rate;
      rec_min_enc <= min_code;
      rec_hr_enc  <= hr_code;
      rec_days    <= days;
      rec_id1     <= id1;
      rec_id2     <= id2;
    end
  end
endmodule

// File: rtl/fclk_follower.sv
module fclk_follower
  import fclk_pkg::*;
#(
  parameter int RATE_W     = 7,
  parameter int DAY_W      = 7,
  parameter int ID_W       = 7,
  parameter int MIN_THRESH = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              sync_valid,
  input  logic [7:0]        sync_ctrl,
  input  logic [RATE_W-1:0] sync_rate,
  input  logic [7:0]        sync_min_enc,
  input  logic [7:0]        sync_hr_enc,
  input  logic [DAY_W-1:0]  sync_days,
  input  logic [ID_W-1:0]   sync_id1,
  input  logic [ID_W-1:0]   sync_id2,
  input  logic              rd_req,
  output logic [5:0]        minute,
  output logic [4:0]        hour,
  output logic [DAY_W-1:0]  days,
  output logic [RATE_W-1:0] rate,
  output logic              never_set,
  output logic              rec_valid,
  output logic [7:0]        rec_ctrl,
  output logic [RATE_W-1:0] rec_rate,
  output logic [7:0]        rec_min_enc,
  output logic [7:0]        rec_hr_enc,
  output logic [DAY_W-1:0]  rec_days,
  output logic [ID_W-1:0]   rec_id1,
  output logic [ID_W-1:0]   rec_id2
);
  logic                load, step;
  logic [RATE_W-1:0]   rate_q;
  logic [ID_W-1:0]     id1_q, id2_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [MIN_BITS-1:0] ld_min;
  logic [HR_BITS-1:0]  ld_hr;

  assign load   = sync_valid & sync_ctrl[VALID_BIT];
  assign ld_min = code_to_min(sync_min_enc);
  assign ld_hr  = code_to_hr(sync_hr_enc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      id1_q  <= '0;
      id2_q  <= '0;
      ctrl_q <= CTRL_AT_RESET;
    end else if (load) begin
      rate_q <= sync_rate;
      id1_q  <= sync_id1;
      id2_q  <= sync_id2;
      ctrl_q <= sync_ctrl;
    end
  end

  fclk_phase #(.RATE_W(RATE_W), .MIN_THRESH(MIN_THRESH)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .clear(load),
    .rate(rate_q), .step(step)
  );

  fclk_tod #(.DAY_W(DAY_W)) u_tod (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load),
    .ld_min(ld_min), .ld_hr(ld_hr), .ld_days(sync_days),
    .minute(minute), .hour(hour), .days(days)
  );

  fclk_snap #(.RATE_W(RATE_W), .DAY_W(DAY_W), .ID_W(ID_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .minute(minute), .hour(hour), .days(days), .rate(rate_q),
    .id1(id1_q), .id2(id2_q), .ctrl(ctrl_q),
    .rec_valid(rec_valid), .rec_ctrl(rec_ctrl), .rec_rate(rec_rate),
    .rec_min_enc(rec_min_enc), .rec_hr_enc(rec_hr_enc), .rec_days(rec_days),
    .rec_id1(rec_id1), .rec_id2(rec_id2)
  );

  assign rate      = rate_q;
  assign never_set = (id1_q == '0) && (id2_q == '0);
endmodule

// File: rtl/fclk_follower_chk.sv
module fclk_follower_chk #(
  parameter int RATE_W = 7,
  parameter int DAY_W  = 7,
  parameter int ID_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              sync_valid,
  input logic [7:0]        sync_ctrl,
  input logic [RATE_W-1:0] sync_rate,
  input logic [DAY_W-1:0]  sync_days,
  input logic [ID_W-1:0]   sync_id1,
  input logic [ID_W-1:0]   sync_id2,
  input logic              rd_req,
  input logic [5:0]        minute,
  input logic [4:0]        hour,
  input logic [DAY_W-1:0]  days,
  input logic [RATE_W-1:0] rate,
  input logic              never_set,
  input logic              rec_valid,
  input logic [7:0]        rec_min_enc
);
  logic accept;
  assign accept = sync_valid && sync_ctrl[6];

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (minute < 6'd60) && (hour < 5'd24));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (minute == $past(minute)) || (minute == $past(minute) + 6'd1) ||
                (($past(minute) == 6'd59) && (minute == 6'd0) && (hour != $past(hour))));

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0 && !sync_valid) |=> $stable(minute) && $stable(hour) && $stable(days));

  assert_notick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !accept) |=> $stable(minute));

  assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && !sync_ctrl[6] && !ref_tick) |=>
      $stable(minute) && $stable(hour) && $stable(days) && $stable(rate) && $stable(never_set));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rate == $past(sync_rate)) && (days == $past(sync_days)));

  assert_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> never_set == (($past(sync_id1) == '0) && ($past(sync_id2) == '0)));

  assert_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rec_valid);

  assert_nord_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rec_valid);

  assert_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> 8'(rec_min_enc + {2'b00, $past(minute)}) == 8'd0);
endmodule

bind fclk_follower fclk_follower_chk #(.RATE_W(RATE_W), .DAY_W(DAY_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/fclk_follower_test.sv
`timescale 1ns/1ps
module fclk_follower_test;
  localparam int THR = 240;

  logic       clk, rst_n;
  logic       ref_tick, sync_valid, rd_req;
  logic [7:0] sync_ctrl, sync_min_enc, sync_hr_enc;
  logic [6:0] sync_rate, sync_days, sync_id1, sync_id2;
  logic [5:0] minute;
  logic [4:0] hour;
  logic [6:0] days, rate, rec_rate, rec_days, rec_id1, rec_id2;
  logic       never_set, rec_valid;
  logic [7:0] rec_ctrl, rec_min_enc, rec_hr_enc;

  fclk_follower uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sync_valid(sync_valid),
    .sync_ctrl(sync_ctrl), .sync_rate(sync_rate), .sync_min_enc(sync_min_enc),
    .sync_hr_enc(sync_hr_enc), .sync_days(sync_days), .sync_id1(sync_id1),
    .sync_id2(sync_id2), .rd_req(rd_req), .minute(minute), .hour(hour),
    .days(days), .rate(rate), .never_set(never_set), .rec_valid(rec_valid),
    .rec_ctrl(rec_ctrl), .rec_rate(rec_rate), .rec_min_enc(rec_min_enc),
    .rec_hr_enc(rec_hr_enc), .rec_days(rec_days), .rec_id1(rec_id1), .rec_id2(rec_id2)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_acc, m_min, m_hr, m_day, m_rate, m_id1, m_id2;
  logic [7:0] m_ctrl;
  logic [51:0] exp_q[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [51:0] model_rec();
    return {m_ctrl, 8'((256 - m_min) % 256), 8'((256 - m_hr) % 256),
            7'(m_day), 7'(m_rate), 7'(m_id1), 7'(m_id2)};
  endfunction

  task automatic model_tick();
    m_acc += m_rate;
    if (m_acc >= THR) begin
      m_acc -= THR;
      m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin m_hr = 0; m_day = (m_day + 1) % 128; end
      end
    end
  endtask

  // one cycle of stimulus; the model follows at the clock edge
  task automatic cyc(input bit tk, input bit sv, input logic [7:0] ct,
                     input logic [7:0] me, input logic [7:0] he, input int dy,
                     input int rt, input int a, input int b, input bit rd);
    @(negedge clk);
    ref_tick = tk; sync_valid = sv; sync_ctrl = ct; sync_min_enc = me;
    sync_hr_enc = he; sync_days = 7'(dy); sync_rate = 7'(rt);
    sync_id1 = 7'(a); sync_id2 = 7'(b); rd_req = rd;
    if (rd) exp_q.push_back(model_rec());
    @(posedge clk);
    if (sv && ct[6]) begin
      m_min = ((256 - me) % 256) % 60; m_hr = ((256 - he) % 256) % 24;
      m_day = dy; m_rate = rt; m_id1 = a; m_id2 = b; m_ctrl = ct; m_acc = 0;
    end else if (tk) model_tick();
    #1;
    ref_tick = 0; sync_valid = 0; rd_req = 0;
  endtask

  task automatic tick();  cyc(1, 0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0); endtask
  task automatic rd();    cyc(0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1); endtask
  task automatic idle();  cyc(0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0); endtask

  task automatic chk_time(input string tag);
    chk({tag, " minute"}, minute, m_min);
    chk({tag, " hour"}, hour, m_hr);
    chk({tag, " days"}, days, m_day);
  endtask

  // scoreboard monitor: every record is compared against the queued expectation
  always @(negedge clk) begin
    if (rst_n && rec_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected record actual=1 expected=0");
      end else begin
        logic [51:0] e, a;
        e = exp_q.pop_front();
        a = {rec_ctrl, rec_min_enc, rec_hr_enc, rec_days, rec_rate, rec_id1, rec_id2};
        if (a !== e) begin
          failures++;
          $display("FAIL R7 record actual=%h expected=%h", a, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ref_tick = 0; sync_valid = 0; rd_req = 0; sync_ctrl = 0; sync_rate = 0;
    sync_min_enc = 0; sync_hr_enc = 0; sync_days = 0; sync_id1 = 0; sync_id2 = 0;
    m_acc = 0; m_min = 0; m_hr = 0; m_day = 0; m_rate = 0; m_id1 = 0; m_id2 = 0;
    m_ctrl = 8'h40;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk_time("R1");
    chk("R1 rate", rate, 0);
    chk("R1 never_set", never_set, 1);
    chk("R1 rec_valid", rec_valid, 0);
    rd();                     // R7 record of 0:00 encodes as 0, ctrl 0x40

    // R2 rate 0 keeps the clock frozen
    repeat (20) tick();
    chk_time("R2 frozen");

    // R5 record without valid bit is ignored
    cyc(0, 1, 8'h3F, 8'd211, 8'd233, 9, 50, 3, 4, 0);
    chk_time("R5 ignored");
    chk("R5 rate", rate, 0);
    chk("R5 never_set", never_set, 1);
    rd();

    // R4 R6 valid sync: 45 min, 23 h, day 127, rate 10, id 5/0
    cyc(0, 1, 8'h41, 8'd211, 8'd233, 127, 10, 5, 0, 0);
    chk_time("R4 load");
    chk("R4 rate", rate, 10);
    chk("R6 never_set after id 5", never_set, 0);

    // R2 24 ticks at rate 10 make one minute
    repeat (23) tick();
    chk("R2 before threshold", minute, 45);
    tick();
    chk("R2 at threshold", minute, 46);

    // R3 R7 read together with the day rollover
    while (!(m_min == 59 && m_hr == 23 && m_acc + m_rate >= THR)) tick();
    chk_time("R3 at 23:59");
    cyc(1, 0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1);
    chk_time("R3 rollover");
    chk("R3 day wrap", days, 0);
    idle();

    // R4 partial phase then sync with a tick in the same cycle
    repeat (10) tick();
    cyc(1, 1, 8'h40, 8'd0, 8'd0, 2, 127, 0, 0, 0);
    chk_time("R4 reload zero");
    chk("R6 never_set after id 0/0", never_set, 1);
    tick();
    chk("R4 phase cleared", minute, 0);
    for (int i = 0; i < 40; i++) begin
      tick();
      chk_time("R2 rate 127");
    end
    rd();                     // R7 encoded record at rate 127

    // R7 read together with an accepted sync; R4 out-of-range codes reduce
    cyc(0, 1, 8'hC0, 8'd186, 8'd226, 7, 1, 0, 9, 1);
    chk_time("R4 modulo");
    chk("R4 minute 70 mod 60", minute, 10);
    chk("R4 hour 30 mod 24", hour, 6);
    rd();
    repeat (THR - 1) tick();
    chk("R2 real rate hold", minute, 10);
    tick();
    chk("R2 real rate step", minute, 11);

    repeat (3) idle();
    chk("R7 all records seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule